// File: doc/BRIEF.md
# Timer Compare Match Unit

The unit holds a 16-bit compare value and a 4-bit action code. On every clock it compares the stored value against the count of an external free-running 16-bit timer. When the two become equal, the unit performs the action the code selects: drive its output latch high, drive it low, raise only the interrupt flag, or issue a trigger. The trigger asks the timer to clear, which turns the compare value into a programmable timer period, and it also asks an external converter to start when that converter is enabled.

Software reaches the unit through a single write port with a select field. Select 0 loads the compare value, select 1 loads the action code, and select 2 clears the interrupt flag. The output latch is presented as a data and enable pair, and the enable follows an external tristate control. A match is detected as an edge, so a timer that stops on the compare value causes only one action. The timer and the converter are outside the unit. The trigger path drives only the timer-clear and convert-start strobes and has no effect on any timer overflow flag.

Top module: `cmp_match_unit`

## Requirements
- R1: After reset, pin_o, irq_o, timer_clr_o and conv_start_o are 0, and the action code is 4'b0000, which is disabled.
- R2: With code 4'b1000, a match on the clock edge where timer_i equals the compare value sets pin_o to 1 from that edge on.
- R3: With code 4'b1001, a match clears pin_o to 0 from that edge on.
- R4: With code 4'b1010, a match leaves pin_o unchanged and only sets irq_o.
- R5: With code 4'b1011, a match pulses timer_clr_o high for exactly one cycle and leaves pin_o unchanged. conv_start_o pulses in the same cycle only if adc_en_i is 1.
- R6: irq_o is set by a match under any of the four active codes and stays set until a write with wr_sel_i=2 and wr_data_i[0]=1. If a set and a clear fall on the same edge, the set wins.
- R7: Any code other than 4'b1000 to 4'b1011 disables compare: a match changes neither pin_o nor irq_o, and it pulses no strobe.
- R8: While timer_i stays equal to the compare value, only one action is performed. A new action needs the match to go away first.
- R9: A write with wr_sel_i=1 whose data[3:0] is 4'b0000 forces the output latch, and so pin_o, to 0.
- R10: pin_oe_o is 1 exactly when tris_i is 0. It is combinational.
- R11: All 16 bits take part in the comparison. A timer value that differs from the compare value in any bit, including the upper byte, does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 compare value, 1 action code, 2 flag clear |
| wr_data_i | input | 16 | Write data |
| timer_i | input | 16 | Count of the external timer |
| adc_en_i | input | 1 | Converter enabled; gates conv_start_o |
| tris_i | input | 1 | Tristate control; 1 releases the pin |
| timer_clr_o | output | 1 | One-cycle request to clear the timer |
| conv_start_o | output | 1 | One-cycle converter start request |
| irq_o | output | 1 | Sticky compare interrupt flag |
| pin_oe_o | output | 1 | Output enable for the pin |
| pin_o | output | 1 | Compare output latch |

## Verification
A wrong compare register or action code shows up one edge after the timer reaches the programmed value: the latch moves the wrong way, or irq_o or timer_clr_o fails to change. A stuck previous-match register shows up either as missing actions or as repeated strobes and a re-set flag while the timer is held on the compare value, and this is visible within two cycles. The interrupt flag state can be observed directly at irq_o after each clear write, so corruption of it shows up in the very next cycle.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam logic [3:0] MODE_OFF    = 4'b0000;
  localparam logic [3:0] MODE_SET_HI = 4'b1000;
  localparam logic [3:0] MODE_SET_LO = 4'b1001;
  localparam logic [3:0] MODE_SWI    = 4'b1010;
  localparam logic [3:0] MODE_TRIG   = 4'b1011;

  localparam logic [1:0] SEL_CMP  = 2'd0;
  localparam logic [1:0] SEL_CTRL = 2'd1;
  localparam logic [1:0] SEL_CLR  = 2'd2;

  typedef struct packed {
    logic set_hi;
    logic set_lo;
    logic trig;
  } act_t;
endpackage

// File: rtl/cmp_regs.sv
module cmp_regs import cmp_pkg::*; #(
  parameter int TW = 16,
  parameter int MW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [TW-1:0] wr_data_i,
  input  logic          evt_i,
  output logic [TW-1:0] cmp_o,
  output logic [MW-1:0] mode_o,
  output logic          ctrl_zero_o,
  output logic          irq_o
);
  logic irq_clr;

  assign irq_clr     = wr_en_i && wr_sel_i == SEL_CLR && wr_data_i[0];
  assign ctrl_zero_o = wr_en_i && wr_sel_i == SEL_CTRL && wr_data_i[MW-1:0] == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_o  <= '0;
      mode_o <= MODE_OFF;
    end else if (wr_en_i) begin
      if (wr_sel_i == SEL_CMP)  cmp_o  <= wr_data_i;
      if (wr_sel_i == SEL_CTRL) mode_o <= wr_data_i[MW-1:0];
    end
  end

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      irq_o <= 1'b0;
    else if (evt_i)   irq_o <= 1'b1;
    else if (irq_clr) irq_o <= 1'b0;
  end

  // R6
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !irq_clr |=> irq_o);
  // R6
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> irq_o);
endmodule

// File: rtl/cmp_detect.sv
module cmp_detect import cmp_pkg::*; #(
  parameter int TW = 16,
  parameter int MW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] timer_i,
  input  logic [TW-1:0] cmp_i,
  input  logic [MW-1:0] mode_i,
  output logic          evt_o,
  output act_t          act_o
);
  logic active, match_now, match_d;

  assign active    = mode_i inside {MODE_SET_HI, MODE_SET_LO, MODE_SWI, MODE_TRIG};
  assign match_now = active && timer_i == cmp_i;
  assign evt_o     = match_now && !match_d;

  always_comb begin
    act_o        = '0;
    act_o.set_hi = evt_o && mode_i == MODE_SET_HI;
    act_o.set_lo = evt_o && mode_i == MODE_SET_LO;
    act_o.trig   = evt_o && mode_i == MODE_TRIG;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_d <= 1'b0;
    else         match_d <= match_now;
  end

  // R8
  one_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o);
  // R7
  off_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> !evt_o);
endmodule

// File: rtl/cmp_action.sv
module cmp_action import cmp_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  act_t act_i,
  input  logic ctrl_zero_i,
  input  logic adc_en_i,
  output logic pin_o,
  output logic timer_clr_o,
  output logic conv_start_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pin_o <= 1'b0;
    else if (ctrl_zero_i) pin_o <= 1'b0;
    else if (act_i.set_hi) pin_o <= 1'b1;
    else if (act_i.set_lo) pin_o <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timer_clr_o  <= 1'b0;
      conv_start_o <= 1'b0;
    end else begin
      timer_clr_o  <= act_i.trig;
      conv_start_o <= act_i.trig && adc_en_i;
    end
  end

  // R5
  clr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timer_clr_o |=> !timer_clr_o);
  // R5
  conv_with_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> timer_clr_o);
  // R4
  pin_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_i.set_hi && !act_i.set_lo && !ctrl_zero_i |=> $stable(pin_o));
  // R9
  pin_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_zero_i |=> !pin_o);
endmodule

// File: rtl/cmp_match_unit.sv
module cmp_match_unit import cmp_pkg::*; #(
  parameter int TW = 16,
  parameter int MW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [TW-1:0] wr_data_i,
  input  logic [TW-1:0] timer_i,
  input  logic          adc_en_i,
  input  logic          tris_i,
  output logic          timer_clr_o,
  output logic          conv_start_o,
  output logic          irq_o,
  output logic          pin_oe_o,
  output logic          pin_o
);
  logic [TW-1:0] cmp_q;
  logic [MW-1:0] mode_q;
  logic          ctrl_zero, evt;
  act_t          act;

  cmp_regs #(.TW(TW), .MW(MW)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .evt_i(evt), .cmp_o(cmp_q), .mode_o(mode_q),
    .ctrl_zero_o(ctrl_zero), .irq_o
  );

  cmp_detect #(.TW(TW), .MW(MW)) i_detect (
    .clk_i, .rst_ni, .timer_i, .cmp_i(cmp_q), .mode_i(mode_q),
    .evt_o(evt), .act_o(act)
  );

  cmp_action i_action (
    .clk_i, .rst_ni, .act_i(act), .ctrl_zero_i(ctrl_zero), .adc_en_i,
    .pin_o, .timer_clr_o, .conv_start_o
  );

  assign pin_oe_o = !tris_i;

  // R2
  set_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt && mode_q == MODE_SET_HI && !ctrl_zero |=> pin_o);
  // R3
  set_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt && mode_q == MODE_SET_LO |=> !pin_o);
endmodule

// File: tb/test_cmp_match_unit.sv
module test_cmp_match_unit;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0;
  logic [1:0]  wr_sel = 0;
  logic [15:0] wr_data = 0, timer = 0;
  logic        adc_en = 0, tris = 1;
  logic        timer_clr, conv_start, irq, pin_oe, pin;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  cmp_match_unit i_cmp_match_unit (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .timer_i(timer), .adc_en_i(adc_en), .tris_i(tris),
    .timer_clr_o(timer_clr), .conv_start_o(conv_start), .irq_o(irq),
    .pin_oe_o(pin_oe), .pin_o(pin)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  // drive timer at a negedge; the result is sampled at the next negedge
  task automatic tick(logic [15:0] t);
    @(negedge clk); timer = t;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 pin", pin, 0); chk("R1 irq", irq, 0);
    chk("R1 clr", timer_clr, 0); chk("R1 conv", conv_start, 0);
  endtask

  task automatic t_set_high;
    wr(0, 16'h1234); wr(1, 16'h0008);
    tick(16'h1233); chk("R2 before match", pin, 0);
    tick(16'h1234); chk("R2 pin high", pin, 1); chk("R6 irq set", irq, 1);
    chk("R2 no clr", timer_clr, 0);
  endtask

  task automatic t_irq_clear;
    wr(2, 16'h0001); chk("R6 irq cleared", irq, 0);
    tick(16'h1234); tick(16'h1234);
    chk("R8 no repeat irq", irq, 0); chk("R8 pin kept", pin, 1);
  endtask

  task automatic t_set_low;
    tick(16'h0000); wr(1, 16'h0009);
    tick(16'h1234); chk("R3 pin low", pin, 0); chk("R6 irq R3", irq, 1);
    wr(2, 16'h0001);
  endtask

  task automatic t_swint;
    tick(16'h0000); wr(1, 16'h0008); tick(16'h1234); chk("R2 pin high again", pin, 1);
    wr(2, 16'h0001);
    tick(16'h0000); wr(1, 16'h000A);
    tick(16'h1234); chk("R4 pin unchanged", pin, 1); chk("R4 irq", irq, 1);
    chk("R4 no clr", timer_clr, 0);
    wr(2, 16'h0001);
  endtask

  task automatic t_zero;
    wr(1, 16'h0000); chk("R9 latch forced low", pin, 0);
  endtask

  task automatic t_disabled;
    wr(1, 16'h0004); tick(16'h0000); tick(16'h1234);
    chk("R7 irq code4", irq, 0); chk("R7 pin code4", pin, 0);
    tick(16'h0000); wr(1, 16'h000C); tick(16'h1234);
    chk("R7 irq codeC", irq, 0); chk("R7 clr codeC", timer_clr, 0);
  endtask

  task automatic t_trigger;
    adc_en = 1; tick(16'h0000); wr(1, 16'h000B);
    tick(16'h1234);
    chk("R5 clr pulse", timer_clr, 1); chk("R5 conv pulse", conv_start, 1);
    chk("R6 irq trig", irq, 1); chk("R5 pin kept", pin, 0);
    @(negedge clk);
    chk("R5 clr one cycle", timer_clr, 0); chk("R8 conv one cycle", conv_start, 0);
    wr(2, 16'h0001);
    adc_en = 0; tick(16'h0000); tick(16'h1234);
    chk("R5 clr no adc", timer_clr, 1); chk("R5 conv gated", conv_start, 0);
    wr(2, 16'h0001);
  endtask

  task automatic t_width;
    tick(16'h0000); wr(1, 16'h0008);
    tick(16'h0034); chk("R11 upper byte differs", pin, 0);
    tick(16'h1334); chk("R11 one upper bit", pin, 0); chk("R11 irq", irq, 0);
    tick(16'h1234); chk("R11 full match", pin, 1);
  endtask

  task automatic t_oe;
    @(negedge clk); tris = 1; #1 chk("R10 released", pin_oe, 0);
    tris = 0; #1 chk("R10 driven", pin_oe, 1);
  endtask

  task automatic t_set_wins;
    wr(1, 16'h0000); tick(16'h0000); wr(1, 16'h000A); wr(2, 16'h0001);
    @(negedge clk); timer = 16'h1234; wr_en = 1; wr_sel = 2; wr_data = 16'h0001;
    @(negedge clk); wr_en = 0;
    chk("R6 set beats clear", irq, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_set_high(); t_irq_clear(); t_set_low(); t_swint(); t_zero();
    t_disabled(); t_trigger(); t_width(); t_oe(); t_set_wins();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule